// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a single-cycle request bus and an external asynchronous static RAM of 128K words by 8 bits. A request presents an address, write data and a read or write strobe while the controller is ready. The controller latches the request, drops ready, and plays out the memory strobes: two chip enables of opposite polarity, an active-low output enable, an active-low write enable, and an 8-bit data bus. The data bus is split into output data, input data and a driver-enable pin. When no request is pending, the memory is held in standby with every strobe released.

Each phase length is counted in clocks. The counts come from nanosecond timing parameters rounded up against a clock-period parameter. A read holds both enables and output enable active for the access time and samples the data bus on the last edge of that phase. Read data is then returned with a one-clock valid pulse. A recovery phase follows, with output enable released, so that the memory's outputs are off before anything else can drive the bus. A write is controlled by write enable. Address and enables are set one clock ahead of the write pulse. Output enable stays high for the whole write. The controller drives data during the write pulse and for one clock after write enable rises. The address only moves while write enable is high.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever idle: `mem_ce_no`=1, `mem_ce2_o`=0, `mem_oe_no`=1, `mem_we_no`=1, `mem_dq_oe_o`=0 and `ready_o`=1.
- R2: A read drives `mem_ce_no`=0, `mem_ce2_o`=1, `mem_oe_no`=0 and `mem_we_no`=1 for RD_CYC clocks. RD_CYC is the largest of ceil(T_AA/CLK), ceil(T_OE/CLK) and ceil(T_RC/CLK)-HZ_CYC, which is 3 at 20 ns. The controller samples `mem_dq_i` on the last edge of that phase. `rvalid_o` is high for exactly one clock, RD_CYC+1 clocks after the accepting edge, and `rdata_o` carries the sampled byte.
- R3: During a write, `mem_we_no` is low for WP_CYC clocks. WP_CYC is the largest of ceil(T_WP/CLK), ceil(T_DW/CLK) and ceil(T_WC/CLK)-2, which is 3 at 20 ns. `mem_oe_no` stays high and `mem_dq_oe_o` stays high throughout the pulse. `mem_dq_o` is constant during the pulse and is still driven on the clock after `mem_we_no` rises.
- R4: `mem_addr_o` never changes while `mem_we_no` is low.
- R5: `mem_we_no` is low only while `mem_ce_no`=0 and `mem_ce2_o`=1. The enables are active one clock before the write pulse and one clock after it.
- R6: `mem_dq_oe_o` is never high while `mem_oe_no` is low, nor within HZ_CYC = ceil(T_HZ/CLK) clocks after `mem_oe_no` rises.
- R7: `ready_o` is low from the accepting edge until the cycle ends: RD_CYC+HZ_CYC clocks for a read and WP_CYC+2 clocks for a write. Requests made while `ready_o` is low have no effect on the memory or the outputs.
- R8: When `req_rd_i` and `req_wr_i` are both high on an accepting edge, the write is performed and no read data is returned.
- R9: Data written to any address, including 0 and 0x1FFFF, reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | 17 | Request word address |
| req_wdata_i | input | 8 | Request write data |
| req_rd_i | input | 1 | Read request |
| req_wr_i | input | 1 | Write request (wins over read) |
| ready_o | output | 1 | High when a request will be accepted |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | One-clock read data valid |
| mem_addr_o | output | 17 | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_ce2_o | output | 1 | Memory second chip enable, active high |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe_o | output | 1 | Enable of the controller's data driver |
| mem_dq_i | input | 8 | Data from memory |

## Verification
A phase counter that is loaded with the wrong value shows up as a busy window of the wrong length within one transaction. A read phase that is too short samples the memory model before its data is valid and returns a poison byte on `rvalid_o` three clocks after the request. A wrong state decode shows up on the same clock as the bad strobe. It appears as write enable low without both enables, a moving address under a low write enable, or the data driver enabled against an active output enable, and the memory model flags each of these at that clock. A corrupted capture path shows up only at read-back, so every written byte is read again, including the extreme addresses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_REC, ST_WA, ST_WP, ST_WH
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } stb_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic stb_t stb_of(input state_e s);
    case (s)
      ST_RD:   return '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      ST_WA:   return '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      ST_WP:   return '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      ST_WH:   return '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
      default: return '{ce_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    endcase
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i - TW'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);

  // R2 R3: a phase of zero clocks would collapse a timing window
  load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0));

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          smp_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (cap_i) begin
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= smp_i;
      if (smp_i) rdata_o <= mem_dq_i;
    end
  end

  // R2
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 30,
  parameter int T_HZ_NS   = 20,
  parameter int T_WC_NS   = 55,
  parameter int T_WP_NS   = 45,
  parameter int T_DSU_NS  = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_rd_i,
  input  logic          req_wr_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_ce2_o,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int HZ_CYC = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int RD_CYC = max3(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS),
                               ns2cyc(T_RC_NS, CLK_NS) - HZ_CYC);
  localparam int WP_CYC = max3(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DSU_NS, CLK_NS),
                               ns2cyc(T_WC_NS, CLK_NS) - 2);
  localparam int MAX_CYC = max3(HZ_CYC, RD_CYC, WP_CYC);
  localparam int TW      = $clog2(MAX_CYC + 1) + 1;
  localparam logic [TW-1:0] ONE_V = TW'(1);
  localparam logic [TW-1:0] HZ_V  = TW'(HZ_CYC);
  localparam logic [TW-1:0] RD_V  = TW'(RD_CYC);
  localparam logic [TW-1:0] WP_V  = TW'(WP_CYC);

  state_e        st_q, st_d;
  stb_t          stb_q;
  logic          ld, cap, smp, done;
  logic [TW-1:0] ld_val;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = ONE_V;
    cap    = 1'b0;
    smp    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_wr_i) begin
          st_d = ST_WA; ld = 1'b1; ld_val = ONE_V; cap = 1'b1;
        end else if (req_rd_i) begin
          st_d = ST_RD; ld = 1'b1; ld_val = RD_V; cap = 1'b1;
        end
      end
      ST_RD:  if (done) begin st_d = ST_REC; ld = 1'b1; ld_val = HZ_V; smp = 1'b1; end
      ST_REC: if (done) st_d = ST_IDLE;
      ST_WA:  if (done) begin st_d = ST_WP; ld = 1'b1; ld_val = WP_V; end
      ST_WP:  if (done) begin st_d = ST_WH; ld = 1'b1; ld_val = ONE_V; end
      ST_WH:  if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state so the pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      stb_q <= stb_of(ST_IDLE);
    end else begin
      st_q  <= st_d;
      stb_q <= stb_of(st_d);
    end
  end

  sram_ctl_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (done)
  );

  sram_ctl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .smp_i       (smp),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_dq_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

  assign ready_o     = (st_q == ST_IDLE);
  assign mem_ce_no   = stb_q.ce_n;
  assign mem_ce2_o   = stb_q.ce2;
  assign mem_oe_no   = stb_q.oe_n;
  assign mem_we_no   = stb_q.we_n;
  assign mem_dq_oe_o = stb_q.dq_oe;

  // clocks since output enable was released, saturating
  logic [TW-1:0] hz_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hz_q <= HZ_V;
    else if (!mem_oe_no) hz_q <= '0;
    else if (hz_q < HZ_V) hz_q <= hz_q + ONE_V;
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_no && !mem_ce2_o && mem_oe_no && mem_we_no && !mem_dq_oe_o));
  // R3
  we_oe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && mem_dq_oe_o));
  // R3
  wdata_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));
  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> $stable(mem_addr_o));
  // R5
  we_in_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_ce2_o));
  // R5
  ce_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (!mem_ce_no && mem_ce2_o));
  // R6
  bus_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_no && hz_q >= HZ_V));
  // R7
  busy_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !ready_o);

endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

  localparam int CLK   = 20;
  localparam int RD_E  = 3;   // ceil(55/20)
  localparam int HZ_E  = 1;   // ceil(20/20)
  localparam int WP_E  = 3;   // max(ceil(45/20), ceil(25/20), ceil(55/20)-2)
  localparam int WR_BUSY = WP_E + 2;
  localparam int RD_BUSY = RD_E + HZ_E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_rd = 1'b0, req_wr = 1'b0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        ce_n, ce2, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'hEE;

  int total = 0, bad = 0;
  logic [7:0] mem_m [int];
  logic [7:0] exp_m [int];

  always #(CLK/2) clk = ~clk;

  sram_ctl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_rd_i(req_rd), .req_wr_i(req_wr),
    .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_ce2_o(ce2),
    .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // behavioural memory and strobe monitor
  int          acc = 0, we_lo = 0, since_oe = 10;
  logic        we_prev = 1'b1;
  logic [16:0] addr_prev = '0;
  logic [7:0]  dq_prev = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit rd_act;
      rd_act = !ce_n && ce2 && !oe_n && we_n;
      if (rd_act) acc = (acc > 0 && mem_addr == addr_prev) ? acc + 1 : 1;
      else acc = 0;
      if (rd_act && acc >= RD_E)
        dq_i = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
      else dq_i = 8'hEE;
      since_oe = !oe_n ? 0 : since_oe + 1;
      if (dq_oe && (!oe_n || since_oe <= HZ_E)) chk(0, "R6 driver on while memory may drive", since_oe, HZ_E + 1);
      if (!we_n) begin
        if (ce_n || !ce2) chk(0, "R5 write without both enables", {ce_n, ce2}, 2'b01);
        if (!oe_n) chk(0, "R3 oe low in write", oe_n, 1);
        if (!dq_oe) chk(0, "R3 data not driven in pulse", dq_oe, 1);
        if (!we_prev && mem_addr != addr_prev) chk(0, "R4 address moved under we", mem_addr, addr_prev);
        if (!we_prev && dq_o != dq_prev) chk(0, "R3 data moved under we", dq_o, dq_prev);
        we_lo++;
      end else if (!we_prev) begin
        chk(we_lo == WP_E, "R3 write pulse length", we_lo, WP_E);
        chk(dq_oe && !ce_n && ce2, "R5 R3 hold after we rise", {dq_oe, ce_n, ce2}, 3'b101);
        mem_m[int'(addr_prev)] = dq_prev;
        we_lo = 0;
      end
      we_prev   = we_n;
      addr_prev = mem_addr;
      dq_prev   = dq_o;
    end
  end

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && !ce2 && oe_n && we_n && !dq_oe && ready, "R1 standby after reset",
        {ce_n, ce2, oe_n, we_n, dq_oe, ready}, 6'b101101);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    int n;
    wait_ready();
    req_addr = a; req_wdata = d; req_wr = 1'b1;
    @(negedge clk);
    req_wr = 1'b0;
    n = 1;
    while (!ready) begin @(negedge clk); n++; end
    chk(n - 1 == WR_BUSY, "R7 write busy length", n - 1, WR_BUSY);
    chk(ce_n && !ce2 && oe_n && we_n && !dq_oe, "R1 standby after write",
        {ce_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
    exp_m[int'(a)] = d;
  endtask

  task automatic t_read(input logic [16:0] a, input string tag);
    int n, vcnt, vat;
    logic [7:0] got, expv;
    wait_ready();
    req_addr = a; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    n = 1; vcnt = 0; vat = 0; got = '0;
    while (!ready) begin
      if (rvalid) begin vcnt++; vat = n; got = rdata; end
      @(negedge clk); n++;
    end
    if (rvalid) begin vcnt++; vat = n; got = rdata; end
    expv = exp_m.exists(int'(a)) ? exp_m[int'(a)] : 8'h00;
    chk(vcnt == 1, "R2 single valid pulse", vcnt, 1);
    chk(vat == RD_E + 1, "R2 valid timing", vat, RD_E + 1);
    chk(got == expv, tag, got, expv);
    chk(n - 1 == RD_BUSY, "R7 read busy length", n - 1, RD_BUSY);
  endtask

  task automatic t_ignore();
    logic [16:0] a = 17'h0A5A5;
    logic [7:0]  old;
    int vcnt = 0;
    t_write(a, 8'h3C);
    old = 8'h3C;
    wait_ready();
    req_addr = a; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b1; req_wdata = 8'hC3; req_addr = 17'h00011;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    while (!ready) begin
      if (rvalid) begin vcnt++; chk(rdata == old, "R7 read under busy requests", rdata, old); end
      @(negedge clk);
    end
    if (rvalid) begin vcnt++; chk(rdata == old, "R7 read under busy requests", rdata, old); end
    chk(vcnt == 1, "R7 busy requests add no cycle", vcnt, 1);
    @(negedge clk);
    chk(ready && ce_n && !rvalid, "R7 no late cycle", {ready, ce_n, rvalid}, 3'b110);
    t_read(a, "R7 data kept");
    t_read(17'h00011, "R7 ignored write absent");
  endtask

  task automatic t_collide();
    int n, vcnt;
    wait_ready();
    req_addr = 17'h01234; req_wdata = 8'h5A; req_rd = 1'b1; req_wr = 1'b1;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    n = 1; vcnt = 0;
    while (!ready) begin
      if (rvalid) vcnt++;
      @(negedge clk); n++;
    end
    chk(vcnt == 0, "R8 no read data on collision", vcnt, 0);
    chk(n - 1 == WR_BUSY, "R8 write cycle taken", n - 1, WR_BUSY);
    exp_m[int'(17'h01234)] = 8'h5A;
    t_read(17'h01234, "R8 written value");
  endtask

  task automatic t_edges();
    t_write(17'h00000, 8'h81);
    t_write(17'h1FFFF, 8'h7E);
    t_read(17'h00000, "R9 low address");
    t_read(17'h1FFFF, "R9 high address");
    t_read(17'h00777, "R2 unwritten reads zero");
  endtask

  task automatic t_random();
    logic [16:0] al [16];
    for (int i = 0; i < 16; i++) begin
      al[i] = 17'($urandom);
      t_write(al[i], 8'($urandom));
    end
    for (int i = 0; i < 16; i++) t_read(al[i], "R9 random read-back");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_edges();
    t_collide();
    t_ignore();
    t_random();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule